// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the configuration registers of the message-signaled interrupt capability for one PCI function. Configuration accesses arrive as dword-addressed reads and writes with per-byte enables. The block decodes the ones that fall inside the capability's byte window, which starts at a build-time byte offset. It keeps the control word, the message address (a low dword and, optionally, a high dword), the 16-bit message data, and, when per-vector masking is built in, a mask word and a pending word.

The block sends its live state to an interrupt delivery engine: the enable bit, the log2 of the vector count that software has granted, the full message address, the data and the mask bits. The engine sends back set and clear strobes for the pending bits. Parameters choose 64-bit addressing, per-vector masking and the supported vector count. Those choices move the data, mask and pending registers and change the size of the window. Configuration read data is registered and comes back one cycle after the request.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the enable bit, the granted-count field, the low and high address, the data, the mask and the pending bits all read zero. The capability bits read their build-time values.
- R2: The layout is given in dwords from the window base. Dword 0 bits 31:16 hold the control word: enable at bit 16, capable count log2 at bits 19:17, granted count log2 at bits 22:20, 64-bit capable at bit 23, masking capable at bit 24. The low address is at dword 1. With 64-bit addressing, the high address is at dword 2, data at 3, mask at 4 and pending at 5; without it, data is at 2, mask at 3 and pending at 4. Bits with no register behind them, and dwords outside the window, read zero.
- R3: In the control word only the enable bit and the granted-count field can be written. The capable-count, 64-bit and masking bits ignore writes.
- R4: Address bits 1:0 always read zero. The other low-address bits, the whole high address and the 16 data bits can be written, and each byte changes only when its byte enable is set.
- R5: Only mask bits below the supported vector count N can be written. Mask bits at N and above read zero.
- R6: When a write leaves the function enabled, a granted-count field above the capable value is reduced to the capable value. While the function is disabled, the field keeps whatever value was written.
- R7: Pending bits are set and cleared only by the engine strobes, and clear wins when both hit the same bit. Configuration writes to the pending dword change nothing.
- R8: A write that touches the window and leaves the function enabled discards every pending bit at or above 2^granted. A touching write that leaves the function disabled keeps all pending bits.
- R9: Writes to dwords outside the window leave every register and output unchanged.
- R10: The enable, granted-count, address, data, mask and pending outputs always carry the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw | input | DW_AW | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| cfg_rvalid | output | 1 | Read data valid |
| msi_en | output | 1 | Message interrupts enabled |
| msi_vec_log2 | output | 3 | Granted vector count, log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 2^VEC_LOG2 | Per-vector mask bits |
| pend_set | input | 2^VEC_LOG2 | Engine sets pending bits |
| pend_clr | input | 2^VEC_LOG2 | Engine clears pending bits |
| pend_out | output | 2^VEC_LOG2 | Pending bits |

## Verification
The hardest case to reach is the discard of pending bits. Pending bits first have to be built up through the engine strobes while the function is enabled with a wide grant. Then a control write has to narrow the grant while keeping the function enabled. The stimulus sets every pending bit, clears a few of them so that the survivors sit on both sides of the new limit, narrows the grant, and reads pending back. It then repeats the same steps with the function disabled, where every bit must survive.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned CTL_EN_BIT  = 16;
  localparam int unsigned CTL_MMC_LSB = 17;
  localparam int unsigned CTL_MME_LSB = 20;
  localparam int unsigned CTL_A64_BIT = 23;
  localparam int unsigned CTL_PVM_BIT = 24;

  typedef struct packed {
    logic ctl;
    logic alo;
    logic ahi;
    logic dat;
    logic msk;
    logic pnd;
  } msi_sel_t;

  function automatic int unsigned cap_bytes(input bit a64, input bit pvm);
    if (pvm) return a64 ? 32'd24 : 32'd20;
    return a64 ? 32'd14 : 32'd10;
  endfunction

  function automatic int unsigned data_dw(input bit a64);
    return a64 ? 32'd3 : 32'd2;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned DW_AW    = 10,
  parameter int unsigned CAP_BASE = 32'h50,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVM      = 1'b1
) (
  input  logic [DW_AW-1:0] cfg_dw,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_be,
  output msi_sel_t         sel,
  output logic [3:0]       wbe,
  output logic             touch
);
  localparam int unsigned CAP_SZ  = cap_bytes(ADDR64, PVM);
  localparam int unsigned NDW     = (CAP_SZ + 3) / 4;
  localparam int unsigned BASE_DW = CAP_BASE / 4;
  localparam int unsigned DDW     = data_dw(ADDR64);
  localparam logic [DW_AW-1:0] BASE_V = DW_AW'(BASE_DW);
  localparam logic [DW_AW-1:0] NDW_V  = DW_AW'(NDW);
  localparam logic [DW_AW-1:0] DDW_V  = DW_AW'(DDW);
  localparam logic [DW_AW-1:0] MDW_V  = DW_AW'(DDW + 1);
  localparam logic [DW_AW-1:0] PDW_V  = DW_AW'(DDW + 2);

  logic [DW_AW-1:0] rel;
  logic             in_rng;
  logic [3:0]       vld;

  always_comb begin
    rel    = cfg_dw - BASE_V;
    in_rng = (cfg_dw >= BASE_V) && (rel < NDW_V);
    for (int i = 0; i < 4; i++) begin
      vld[i] = ((32'(rel) << 2) + 32'(i)) < 32'(CAP_SZ);
    end
    sel.ctl = in_rng && (rel == '0);
    sel.alo = in_rng && (rel == DW_AW'(1));
    sel.ahi = ADDR64 && in_rng && (rel == DW_AW'(2));
    sel.dat = in_rng && (rel == DDW_V);
    sel.msk = PVM && in_rng && (rel == MDW_V);
    sel.pnd = PVM && in_rng && (rel == PDW_V);
    wbe     = (cfg_wr && in_rng) ? (cfg_be & vld) : 4'b0000;
    touch   = |wbe;
  end

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int unsigned VEC_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       w_en,
  input  logic [2:0] w_mme,
  input  logic       touch,
  output logic       en_q,
  output logic [2:0] mme_q,
  output logic       en_nx,
  output logic [2:0] mme_nx
);
  localparam logic [2:0] MMC = 3'(VEC_LOG2);

  logic ld;

  always_comb begin
    en_nx  = en_q;
    mme_nx = mme_q;
    if (wr_ctl) begin
      en_nx  = w_en;
      mme_nx = w_mme;
    end
    if (touch && en_nx && (mme_nx > MMC)) mme_nx = MMC;
    ld = wr_ctl || touch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else if (ld) begin
      en_q  <= en_nx;
      mme_q <= mme_nx;
    end
  end

endmodule

// File: rtl/msi_cap_vec.sv
module msi_cap_vec #(
  parameter int unsigned VEC_LOG2 = 3,
  parameter bit          PVM      = 1'b1,
  localparam int unsigned NVEC    = 1 << VEC_LOG2,
  localparam int unsigned NB      = (NVEC + 7) / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   wbe_msk,
  input  logic [NVEC-1:0] wdata,
  input  logic [NVEC-1:0] pend_set,
  input  logic [NVEC-1:0] pend_clr,
  input  logic            discard,
  input  logic [2:0]      mme_nx,
  output logic [NVEC-1:0] mask_o,
  output logic [NVEC-1:0] pend_o
);
  generate
    if (PVM) begin : g_mask
      logic [NVEC-1:0] mask_q, mask_nx, pend_q, pend_nx, keep;
      logic            mask_ld, pend_ld;

      always_comb begin
        mask_nx = mask_q;
        for (int b = 0; b < int'(NVEC); b++) begin
          if (wbe_msk[b/8]) mask_nx[b] = wdata[b];
          keep[b] = (32'(b) >> mme_nx) == 32'd0;
        end
        pend_nx = (pend_q | pend_set) & ~pend_clr;
        if (discard) pend_nx = pend_nx & keep;
        mask_ld = |wbe_msk;
        pend_ld = (|pend_set) || (|pend_clr) || discard;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q <= '0;
          pend_q <= '0;
        end else begin
          if (mask_ld) mask_q <= mask_nx;
          if (pend_ld) pend_q <= pend_nx;
        end
      end

      assign mask_o = mask_q;
      assign pend_o = pend_q;
    end else begin : g_nomask
      assign mask_o = '0;
      assign pend_o = '0;
    end
  endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned DW_AW    = 10,
  parameter int unsigned CAP_BASE = 32'h50,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVM      = 1'b1,
  parameter int unsigned VEC_LOG2 = 3,
  localparam int unsigned NVEC    = 1 << VEC_LOG2,
  localparam int unsigned NB      = (NVEC + 7) / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [DW_AW-1:0] cfg_dw,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_rvalid,
  output logic             msi_en,
  output logic [2:0]       msi_vec_log2,
  output logic [63:0]      msg_addr,
  output logic [15:0]      msg_data,
  output logic [NVEC-1:0]  vec_mask,
  input  logic [NVEC-1:0]  pend_set,
  input  logic [NVEC-1:0]  pend_clr,
  output logic [NVEC-1:0]  pend_out
);
  msi_sel_t   sel;
  logic [3:0] wbe;
  logic       touch;
  logic       en_nx;
  logic [2:0] mme_nx;

  msi_cap_decode #(.DW_AW(DW_AW), .CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .PVM(PVM)) u_dec (
    .cfg_dw(cfg_dw), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .sel(sel), .wbe(wbe), .touch(touch)
  );

  msi_cap_ctrl #(.VEC_LOG2(VEC_LOG2)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(sel.ctl && wbe[2]),
    .w_en(cfg_wdata[CTL_EN_BIT]),
    .w_mme(cfg_wdata[CTL_MME_LSB +: 3]),
    .touch(touch),
    .en_q(msi_en), .mme_q(msi_vec_log2),
    .en_nx(en_nx), .mme_nx(mme_nx)
  );

  msi_cap_vec #(.VEC_LOG2(VEC_LOG2), .PVM(PVM)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wbe_msk(sel.msk ? wbe[NB-1:0] : '0),
    .wdata(cfg_wdata[NVEC-1:0]),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .discard(touch && en_nx),
    .mme_nx(mme_nx),
    .mask_o(vec_mask), .pend_o(pend_out)
  );

  // Low address and data registers
  logic [31:2] alo_q;
  logic [31:0] alo_nx;
  logic [15:0] dat_q, dat_nx;
  logic        alo_ld, dat_ld;

  always_comb begin
    alo_nx = {alo_q, 2'b00};
    for (int i = 0; i < 4; i++) begin
      if (sel.alo && wbe[i]) alo_nx[8*i +: 8] = cfg_wdata[8*i +: 8];
    end
    dat_nx = dat_q;
    for (int i = 0; i < 2; i++) begin
      if (sel.dat && wbe[i]) dat_nx[8*i +: 8] = cfg_wdata[8*i +: 8];
    end
    alo_ld = sel.alo && (|wbe);
    dat_ld = sel.dat && (|wbe[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      dat_q <= '0;
    end else begin
      if (alo_ld) alo_q <= alo_nx[31:2];
      if (dat_ld) dat_q <= dat_nx;
    end
  end

  logic [31:0] ahi;

  generate
    if (ADDR64) begin : g_ahi
      logic [31:0] ahi_q, ahi_nx;
      logic        ahi_ld;
      always_comb begin
        ahi_nx = ahi_q;
        for (int i = 0; i < 4; i++) begin
          if (sel.ahi && wbe[i]) ahi_nx[8*i +: 8] = cfg_wdata[8*i +: 8];
        end
        ahi_ld = sel.ahi && (|wbe);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ahi_q <= '0;
        else if (ahi_ld) ahi_q <= ahi_nx;
      end
      assign ahi = ahi_q;
    end else begin : g_noahi
      assign ahi = '0;
    end
  endgenerate

  assign msg_addr = {ahi, alo_q, 2'b00};
  assign msg_data = dat_q;

  // Registered read path
  logic [31:0] rd_nx;

  always_comb begin
    rd_nx = '0;
    if (sel.ctl) begin
      rd_nx[CTL_EN_BIT]         = msi_en;
      rd_nx[CTL_MMC_LSB +: 3]   = 3'(VEC_LOG2);
      rd_nx[CTL_MME_LSB +: 3]   = msi_vec_log2;
      rd_nx[CTL_A64_BIT]        = ADDR64;
      rd_nx[CTL_PVM_BIT]        = PVM;
    end
    if (sel.alo) rd_nx = {alo_q, 2'b00};
    if (sel.ahi) rd_nx = ahi;
    if (sel.dat) rd_nx = {16'h0000, dat_q};
    if (sel.msk) rd_nx = 32'(vec_mask);
    if (sel.pnd) rd_nx = 32'(pend_out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_nx;
    end
  end

endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int unsigned VEC_LOG2 = 3,
  localparam int unsigned NVEC    = 1 << VEC_LOG2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            msi_en,
  input logic [2:0]      msi_vec_log2,
  input logic [63:0]     msg_addr,
  input logic [15:0]     msg_data,
  input logic [NVEC-1:0] vec_mask,
  input logic [NVEC-1:0] pend_set,
  input logic [NVEC-1:0] pend_clr,
  input logic [NVEC-1:0] pend_out
);
  a_r6_grant_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> (msi_vec_log2 <= 3'(VEC_LOG2)));

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(msi_en) && $stable(msi_vec_log2) && $stable(msg_addr)
                 && $stable(msg_data) && $stable(vec_mask)));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (&pend_clr) |=> (pend_out == '0));

  a_r7_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_set == '0) && (pend_clr == '0) && !cfg_wr) |=> $stable(pend_out));

endmodule

bind msi_cap_regs msi_cap_regs_chk #(.VEC_LOG2(VEC_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .msi_en(msi_en),
  .msi_vec_log2(msi_vec_log2), .msg_addr(msg_addr), .msg_data(msg_data),
  .vec_mask(vec_mask), .pend_set(pend_set), .pend_clr(pend_clr),
  .pend_out(pend_out)
);

// File: tb/msi_cap_regs_tb.sv
`timescale 1ns/100ps
module msi_cap_regs_tb;
  localparam int unsigned DW_AW = 10;
  localparam logic [9:0] D_CTL = 10'h14, D_ALO = 10'h15, D_AHI = 10'h16,
                         D_DAT = 10'h17, D_MSK = 10'h18, D_PND = 10'h19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [9:0]  cfg_dw;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_rvalid, msi_en;
  logic [2:0]  msi_vec_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [7:0]  vec_mask, pend_set, pend_clr, pend_out;

  always #2.5 clk = ~clk;

  msi_cap_regs #(.DW_AW(DW_AW), .CAP_BASE(32'h50), .ADDR64(1'b1), .PVM(1'b1), .VEC_LOG2(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .msi_en(msi_en), .msi_vec_log2(msi_vec_log2), .msg_addr(msg_addr), .msg_data(msg_data),
    .vec_mask(vec_mask), .pend_set(pend_set), .pend_clr(pend_clr), .pend_out(pend_out)
  );

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [9:0] dw, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = dw;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = '0; pend_clr = '0;
  endtask

  // Monitor: compares each returned read with the queued expectation
  always @(negedge clk) begin
    if (rst_n && cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read: actual %h expected none", cfg_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, 64'(cfg_rdata), 64'(it.exp));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_dw = '0; cfg_be = '0; cfg_wdata = '0;
    pend_set = '0; pend_clr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 layout
    rd(D_CTL, 32'h0186_0000, "R1 ctl reset");
    rd(D_ALO, 32'h0, "R1 alo reset");
    rd(D_AHI, 32'h0, "R1 ahi reset");
    rd(D_DAT, 32'h0, "R1 data reset");
    rd(D_MSK, 32'h0, "R1 mask reset");
    rd(D_PND, 32'h0, "R1 pending reset");
    chk("R1 msi_en reset", 64'(msi_en), 64'd0);

    // R3 read-only caps, R6 clamp while enabled
    wr(D_CTL, 4'hF, 32'hFFFF_FFFF);
    rd(D_CTL, 32'h01B7_0000, "R3 R6 ctl all ones");
    chk("R10 msi_en", 64'(msi_en), 64'd1);
    chk("R6 granted clamp", 64'(msi_vec_log2), 64'd3);
    wr(D_CTL, 4'h4, 32'h0070_0000);
    rd(D_CTL, 32'h01F6_0000, "R6 no clamp disabled");
    chk("R10 msi_en off", 64'(msi_en), 64'd0);
    wr(D_CTL, 4'h4, 32'h0071_0000);
    rd(D_CTL, 32'h01B7_0000, "R6 clamp on enable");

    // R4 address and data
    wr(D_ALO, 4'hF, 32'hFFFF_FFFF);
    rd(D_ALO, 32'hFFFF_FFFC, "R4 alo low bits");
    wr(D_ALO, 4'h3, 32'h1234_5678);
    rd(D_ALO, 32'hFFFF_5678, "R4 alo byte enables");
    wr(D_AHI, 4'hF, 32'hCAFE_F00D);
    rd(D_AHI, 32'hCAFE_F00D, "R4 ahi");
    chk("R10 msg_addr", msg_addr, 64'hCAFE_F00D_FFFF_5678);
    wr(D_DAT, 4'hF, 32'hABCD_1234);
    rd(D_DAT, 32'h0000_1234, "R4 R2 data upper zero");
    chk("R10 msg_data", 64'(msg_data), 64'h1234);

    // R5 mask
    wr(D_MSK, 4'hF, 32'hFFFF_FFFF);
    rd(D_MSK, 32'h0000_00FF, "R5 mask high bits zero");
    chk("R10 vec_mask", 64'(vec_mask), 64'hFF);
    wr(D_MSK, 4'hE, 32'h0);
    rd(D_MSK, 32'h0000_00FF, "R5 mask byte enable");
    wr(D_MSK, 4'h1, 32'h5A);
    rd(D_MSK, 32'h0000_005A, "R5 mask write");

    // R7 pending
    wr(D_PND, 4'hF, 32'hFFFF_FFFF);
    rd(D_PND, 32'h0, "R7 pending read-only");
    pulse(8'hFF, 8'h00);
    rd(D_PND, 32'h0000_00FF, "R7 engine set");
    pulse(8'h01, 8'h0D);
    rd(D_PND, 32'h0000_00F2, "R7 clear wins");
    chk("R10 pend_out", 64'(pend_out), 64'hF2);

    // R8 discard when enabled, keep when disabled
    wr(D_CTL, 4'h4, 32'h0011_0000);
    rd(D_CTL, 32'h0197_0000, "R8 ctl narrowed");
    rd(D_PND, 32'h0000_0002, "R8 discard above grant");
    wr(D_CTL, 4'h4, 32'h0);
    pulse(8'hF0, 8'h00);
    wr(D_ALO, 4'hF, 32'hFFFF_5678);
    rd(D_PND, 32'h0000_00F2, "R8 kept while disabled");

    // R9 outside window
    wr(10'h1A, 4'hF, 32'hFFFF_FFFF);
    wr(10'h13, 4'hF, 32'hFFFF_FFFF);
    rd(D_CTL, 32'h0186_0000, "R9 ctl unchanged");
    rd(D_ALO, 32'hFFFF_5678, "R9 alo unchanged");
    rd(D_MSK, 32'h0000_005A, "R9 mask unchanged");
    rd(10'h1A, 32'h0, "R2 outside reads zero");
    rd(10'h13, 32'h0, "R2 below base reads zero");
    chk("R9 msi_en", 64'(msi_en), 64'd0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL reads outstanding: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule